// File: doc/BRIEF.md
# I2C Master Transmitter with Event Status Codes

This block drives an I2C bus as a byte-at-a-time master transmitter. Software works through four byte-wide locations: a control-set location, a status location, a transmit data location and a control-clear location. Once enabled, a start request makes the block wait for a free bus and then drive a START condition. After that it sends the byte placed in the data location, most significant bit first, and then gives the slave a ninth clock on which to acknowledge. A stop request ends the transfer with a STOP condition.

Every bus event halts the engine with SCL held low. The engine then posts an 8-bit code to the status location and raises the interrupt flag. It stays halted until software clears that flag, so software paces the transfer one event at a time. The bus lines are open-drain: the block only ever pulls a line low or lets it go, and it reads both lines back through a two-stage synchronizer. A bus monitor follows START and STOP conditions from any master, so a request made while another master holds the bus is delayed. If another device holds SDA low while this block lets it float high, arbitration is lost. The block then releases both lines and reports the loss.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset the status location reads 0xF8, the control location reads 0x00, irq is 0 and neither line is pulled low.
- R2: A write to the control-set location (address 0) sets enable (bit 6), start request (bit 5), stop request (bit 4) and assert-acknowledge (bit 2) wherever the written bit is 1. Zeros have no effect, and a 1 in bit 3 does not set the interrupt flag. Bits 7, 1 and 0 always read 0.
- R3: A 1 written to the control-clear location (address 3) clears the matching control bit. The interrupt flag (bit 3) is cleared only this way.
- R4: While the bus is busy, a start request causes no activity on SCL or SDA and no interrupt. The bus counts as busy from an observed START (SDA falling while SCL is high) until an observed STOP (SDA rising while SCL is high).
- R5: On a free bus with enable set, a start request produces SDA falling while SCL is high, then SCL low. After that the interrupt flag sets, status reads 0x08 and the start request bit has been cleared by the block.
- R6: Clearing the flag after a START sends the data location (address 2) MSB first on eight SCL pulses. SDA is then released for a ninth pulse that carries the acknowledge.
- R7: After the first byte following START, status is 0x18 if the byte was acknowledged (SDA low on the ninth pulse) and 0x20 if it was not.
- R8: After each later byte, status is 0x28 if it was acknowledged and 0x30 if it was not.
- R9: While the interrupt flag is pending after a byte or START, SCL stays low.
- R10: A stop request set while the flag is pending, followed by clearing the flag, produces SDA rising while SCL is high. The block then clears the stop request bit and status returns to 0xF8 with irq low.
- R11: If the block lets SDA float high but samples it low while SCL is high during a data bit, it releases both lines, sets the flag and reports 0x38. Clearing the flag then returns status to 0xF8.
- R12: With enable clear, a start request produces no bus activity and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the location at addr |
| addr | input | 2 | Location select: 0 set, 1 status, 2 data, 3 clear |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the location at addr (combinational) |
| irq | output | 1 | Interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench places a START from another master on the bus before making its own request. A block that ignores the bus monitor would clock SCL while the bus is busy, and the bench watches for that. A slave model acknowledges or refuses each byte, so the four acknowledge codes are told apart by position. A block that mixes up the address and data phases would report 0x28 where 0x18 is due. A jamming device holds SDA low from the first bit onward. A design that misses the arbitration loss would keep pulling SCL or would report an acknowledge code. The stop case checks that the stop request bit clears itself, which a design that leaves it set would fail.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam int CB_EN  = 6;
    localparam int CB_STA = 5;
    localparam int CB_STO = 4;
    localparam int CB_SI  = 3;
    localparam int CB_AA  = 2;

    localparam logic [1:0] RA_SET  = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_DATA = 2'd2;
    localparam logic [1:0] RA_CLR  = 2'd3;

    localparam logic [7:0] SC_START = 8'h08;
    localparam logic [7:0] SC_AACK  = 8'h18;
    localparam logic [7:0] SC_ANACK = 8'h20;
    localparam logic [7:0] SC_DACK  = 8'h28;
    localparam logic [7:0] SC_DNACK = 8'h30;
    localparam logic [7:0] SC_LOST  = 8'h38;
    localparam logic [7:0] SC_IDLE  = 8'hF8;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_HOLD, PH_BIT, PH_STOP, PH_LOST
    } phase_e;

    typedef struct packed {
        logic en;
        logic sta;
        logic sto;
        logic si;
        logic aa;
    } ctrl_t;

    typedef struct packed {
        logic       valid;
        logic       set_si;
        logic [7:0] code;
    } event_t;

    function automatic logic [7:0] ack_code(input logic first, input logic acked);
        if (first) return acked ? SC_AACK : SC_ANACK;
        return acked ? SC_DACK : SC_DNACK;
    endfunction
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int QDIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(QDIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic busy
);
    logic [1:0] scl_sync, sda_sync;
    logic       sda_prev;

    assign scl_s = scl_sync[1];
    assign sda_s = sda_sync[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            sda_prev <= 1'b1;
            busy     <= 1'b0;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            sda_prev <= sda_s;
            if (scl_s && sda_prev && !sda_s)
                busy <= 1'b1;
            else if (scl_s && !sda_prev && sda_s)
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en_i,
    input  logic       sta_i,
    input  logic       sto_i,
    input  logic       si_i,
    input  logic [7:0] tx_data,
    input  logic       sda_s,
    input  logic       busy,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       sta_done,
    output logic       sto_done,
    output event_t     ev
);
    phase_e     phase;
    logic [1:0] q;
    logic [3:0] bitn;
    logic [7:0] shreg;
    logic       first;
    logic       acked;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            q        <= '0;
            bitn     <= '0;
            shreg    <= '0;
            first    <= 1'b0;
            acked    <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            sta_done <= 1'b0;
            sto_done <= 1'b0;
            ev       <= '0;
        end else begin
            sta_done <= 1'b0;
            sto_done <= 1'b0;
            ev       <= '0;
            if (tick) begin
                case (phase)
                    PH_IDLE: if (en_i && sta_i && !busy) begin
                        phase <= PH_START;
                        q     <= '0;
                    end
                    PH_START: begin
                        q <= q + 1'b1;
                        if (q == 2'd1) sda_oe <= 1'b1;
                        if (q == 2'd3) begin
                            scl_oe   <= 1'b1;
                            sta_done <= 1'b1;
                            first    <= 1'b1;
                            ev       <= '{valid: 1'b1, set_si: 1'b1, code: SC_START};
                            phase    <= PH_HOLD;
                        end
                    end
                    PH_HOLD: if (!si_i) begin
                        q <= '0;
                        if (sto_i) begin
                            phase <= PH_STOP;
                        end else begin
                            shreg <= tx_data;
                            bitn  <= '0;
                            phase <= PH_BIT;
                        end
                    end
                    PH_BIT: begin
                        q <= q + 1'b1;
                        case (q)
                            2'd0: sda_oe <= (bitn == 4'd8) ? 1'b0 : ~shreg[7];
                            2'd1: scl_oe <= 1'b0;
                            2'd2: begin
                                if (bitn != 4'd8 && !sda_oe && !sda_s) begin
                                    scl_oe <= 1'b0;
                                    sda_oe <= 1'b0;
                                    phase  <= PH_LOST;
                                    ev     <= '{valid: 1'b1, set_si: 1'b1, code: SC_LOST};
                                end else if (bitn == 4'd8) begin
                                    acked <= !sda_s;
                                end
                            end
                            default: begin
                                scl_oe <= 1'b1;
                                if (bitn == 4'd8) begin
                                    ev    <= '{valid: 1'b1, set_si: 1'b1, code: ack_code(first, acked)};
                                    first <= 1'b0;
                                    phase <= PH_HOLD;
                                end else begin
                                    shreg <= {shreg[6:0], 1'b0};
                                    bitn  <= bitn + 1'b1;
                                end
                            end
                        endcase
                    end
                    PH_STOP: begin
                        q <= q + 1'b1;
                        case (q)
                            2'd0: sda_oe <= 1'b1;
                            2'd1: scl_oe <= 1'b0;
                            2'd2: sda_oe <= 1'b0;
                            default: begin
                                phase    <= PH_IDLE;
                                sto_done <= 1'b1;
                                ev       <= '{valid: 1'b1, set_si: 1'b0, code: SC_IDLE};
                            end
                        endcase
                    end
                    PH_LOST: if (!si_i) begin
                        phase <= PH_IDLE;
                        ev    <= '{valid: 1'b1, set_si: 1'b0, code: SC_IDLE};
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R9
    hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (si_i && phase == PH_HOLD) |-> scl_oe);

    // R11
    lost_release_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOST) |-> (!scl_oe && !sda_oe));

    // R4
    busy_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && busy) |=> (phase != PH_START));
endmodule

// File: rtl/i2c_mtx_ctrl.sv
module i2c_mtx_ctrl
    import i2cm_pkg::*;
#(
    parameter int QDIV = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe
);
    ctrl_t      ctrl;
    logic [7:0] status;
    logic [7:0] txd;
    logic       tick, scl_s, sda_s, busy, sta_done, sto_done;
    event_t     ev;

    i2cm_tick #(.QDIV(QDIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    i2cm_busmon u_mon (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .busy(busy)
    );

    i2cm_engine u_eng (
        .clk(clk), .rst(rst), .tick(tick),
        .en_i(ctrl.en), .sta_i(ctrl.sta), .sto_i(ctrl.sto), .si_i(ctrl.si),
        .tx_data(txd), .sda_s(sda_s), .busy(busy),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sta_done(sta_done), .sto_done(sto_done), .ev(ev)
    );

    logic unused_scl;
    assign unused_scl = scl_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            status <= SC_IDLE;
            txd    <= '0;
        end else begin
            if (wr_en) begin
                case (addr)
                    RA_SET: begin
                        if (wr_data[CB_EN])  ctrl.en  <= 1'b1;
                        if (wr_data[CB_STA]) ctrl.sta <= 1'b1;
                        if (wr_data[CB_STO]) ctrl.sto <= 1'b1;
                        if (wr_data[CB_AA])  ctrl.aa  <= 1'b1;
                    end
                    RA_DATA: txd <= wr_data;
                    RA_CLR: begin
                        if (wr_data[CB_EN])  ctrl.en  <= 1'b0;
                        if (wr_data[CB_STA]) ctrl.sta <= 1'b0;
                        if (wr_data[CB_STO]) ctrl.sto <= 1'b0;
                        if (wr_data[CB_SI])  ctrl.si  <= 1'b0;
                        if (wr_data[CB_AA])  ctrl.aa  <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (sta_done) ctrl.sta <= 1'b0;
            if (sto_done) ctrl.sto <= 1'b0;
            if (ev.valid) begin
                status <= ev.code;
                if (ev.set_si) ctrl.si <= 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            RA_SET:  rd_data = {1'b0, ctrl.en, ctrl.sta, ctrl.sto, ctrl.si, ctrl.aa, 2'b00};
            RA_STAT: rd_data = status;
            RA_DATA: rd_data = txd;
            default: rd_data = 8'h00;
        endcase
    end

    assign irq = ctrl.si;

    // R3
    si_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.si && !(wr_en && addr == RA_CLR && wr_data[CB_SI])) |=> ctrl.si);

    // R5
    start_code_chk: assert property (@(posedge clk) disable iff (rst)
        sta_done |=> (ctrl.si && status == SC_START && !ctrl.sta));

    // R10
    sto_self_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sto_done |=> (!ctrl.sto && status == SC_IDLE));
endmodule

// File: tb/sim_i2c_mtx_ctrl.sv
module sim_i2c_mtx_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq, scl_oe, sda_oe, scl_w, sda_w;
    logic       ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic       ack_en = 1'b0, jam = 1'b0;
    logic       sl_ack_low = 1'b0, jam_low = 1'b0;
    int         tests = 0, fails = 0;

    always #4 clk = ~clk;

    assign scl_w = ~(scl_oe | ext_scl_low);
    assign sda_w = ~(sda_oe | ext_sda_low | sl_ack_low | jam_low);

    i2c_mtx_ctrl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .scl_i(scl_w), .sda_i(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // slave model: counts clocks after START, captures a byte, acknowledges on request
    logic       p_scl = 1'b1, p_sda = 1'b1, active = 1'b0;
    int         cnt = 0, stops = 0;
    logic [7:0] sh = 8'h00, rx = 8'h00;
    always @(negedge clk) begin
        if (p_scl && scl_w && p_sda && !sda_w) begin
            active <= 1'b1; cnt <= 0;
        end else if (p_scl && scl_w && !p_sda && sda_w) begin
            active <= 1'b0; stops <= stops + 1;
        end else if (active && !p_scl && scl_w) begin
            if (cnt < 8) sh <= {sh[6:0], sda_w};
            cnt <= cnt + 1;
        end else if (active && p_scl && !scl_w) begin
            if (cnt == 8 && ack_en) sl_ack_low <= 1'b1;
            if (cnt == 9) begin sl_ack_low <= 1'b0; cnt <= 0; rx <= sh; end
        end
        jam_low <= jam && (jam_low || (active && p_scl && !scl_w && cnt == 0));
        p_scl <= scl_w;
        p_sda <= sda_w;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; #1 v = rd_data;
    endtask

    task automatic wait_irq(input string tag);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (irq) break;
        end
        chk(irq, tag, {7'd0, irq}, 8'h01);
    endtask

    task automatic wait_idle(input string tag);
        logic [7:0] v = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            rd(2'd1, v);
            if (v == 8'hF8) break;
        end
        chk(v == 8'hF8, tag, v, 8'hF8);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(2'd1, v); chk(v == 8'hF8, "R1 status", v, 8'hF8);
        rd(2'd0, v); chk(v == 8'h00, "R1 control", v, 8'h00);
        chk(!irq && !scl_oe && !sda_oe, "R1 outputs", {5'd0, irq, scl_oe, sda_oe}, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(2'd0, 8'h97); rd(2'd0, v); chk(v == 8'h14, "R2 set bits", v, 8'h14);
        wr(2'd0, 8'h00); rd(2'd0, v); chk(v == 8'h14, "R2 zero write", v, 8'h14);
        wr(2'd0, 8'h08); rd(2'd0, v); chk(v == 8'h14 && !irq, "R2 si not settable", v, 8'h14);
        wr(2'd3, 8'h14); rd(2'd0, v); chk(v == 8'h00, "R3 clear bits", v, 8'h00);
    endtask

    task automatic t_disabled;
        bit moved = 0;
        wr(2'd0, 8'h20);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!scl_w || !sda_w || irq) moved = 1;
        end
        chk(!moved, "R12 no activity when disabled", {7'd0, moved}, 8'h00);
        wr(2'd3, 8'h20);
    endtask

    task automatic t_main;
        logic [7:0] v;
        bit moved = 0;
        int s0;
        ext_sda_low = 1'b1;
        repeat (10) @(negedge clk);
        wr(2'd0, 8'h60);
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!scl_w || irq) moved = 1;
        end
        chk(!moved, "R4 wait while busy", {7'd0, moved}, 8'h00);
        ext_sda_low = 1'b0;
        wait_irq("R5 start irq");
        rd(2'd1, v); chk(v == 8'h08, "R5 start code", v, 8'h08);
        rd(2'd0, v); chk(v[5] == 1'b0, "R5 sta self clear", v, 8'h48);
        chk(!scl_w && !sda_w, "R5 lines low after start", {6'd0, scl_w, sda_w}, 8'h00);
        // address byte, acknowledged
        ack_en = 1'b1;
        wr(2'd2, 8'hA4);
        wr(2'd3, 8'h08);
        wait_irq("R7 addr irq");
        rd(2'd1, v); chk(v == 8'h18, "R7 addr ack code", v, 8'h18);
        chk(rx == 8'hA4, "R6 address byte MSB first", rx, 8'hA4);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (scl_w || !irq) moved = 1;
        end
        chk(!moved, "R9 scl held low while pending", {7'd0, moved}, 8'h00);
        // data byte, acknowledged
        wr(2'd2, 8'h3C);
        wr(2'd3, 8'h08);
        wait_irq("R8 data irq");
        rd(2'd1, v); chk(v == 8'h28, "R8 data ack code", v, 8'h28);
        chk(rx == 8'h3C, "R6 data byte", rx, 8'h3C);
        // data byte, not acknowledged
        ack_en = 1'b0;
        wr(2'd2, 8'h81);
        wr(2'd3, 8'h08);
        wait_irq("R8 nack irq");
        rd(2'd1, v); chk(v == 8'h30, "R8 data nack code", v, 8'h30);
        // stop
        s0 = stops;
        wr(2'd0, 8'h10);
        wr(2'd3, 8'h08);
        wait_idle("R10 status back to idle");
        rd(2'd0, v); chk(v[4] == 1'b0 && !irq, "R10 sto self clear", v, 8'h40);
        chk(stops == s0 + 1, "R10 stop on bus", 8'(stops - s0), 8'h01);
        chk(scl_w && sda_w, "R10 lines released", {6'd0, scl_w, sda_w}, 8'h03);
    endtask

    task automatic t_addr_nack;
        logic [7:0] v;
        ack_en = 1'b0;
        wr(2'd0, 8'h20);
        wait_irq("R5 second start");
        wr(2'd2, 8'h42);
        wr(2'd3, 8'h08);
        wait_irq("R7 addr nack irq");
        rd(2'd1, v); chk(v == 8'h20, "R7 addr nack code", v, 8'h20);
        wr(2'd0, 8'h10);
        wr(2'd3, 8'h08);
        wait_idle("R10 idle after nack stop");
    endtask

    task automatic t_arb;
        logic [7:0] v;
        jam = 1'b1;
        wr(2'd0, 8'h20);
        wait_irq("R11 start before loss");
        wr(2'd2, 8'hA4);
        wr(2'd3, 8'h08);
        wait_irq("R11 loss irq");
        rd(2'd1, v); chk(v == 8'h38, "R11 lost code", v, 8'h38);
        chk(!scl_oe && !sda_oe, "R11 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        jam = 1'b0;
        repeat (20) @(negedge clk);
        wr(2'd3, 8'h08);
        wait_idle("R11 idle after loss");
        chk(!irq, "R11 irq clear", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset;
        t_regs;
        t_disabled;
        t_main;
        t_addr_nack;
        t_arb;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule